// File: doc/BRIEF.md
# Wake Pin Driver Controller

This block holds the digital control for a high-voltage wake pin that asserts a system wake request by driving a shared line high. Software asks for the drive through a request bit. The block decides whether the external driver may actually be switched on. Three protections can take the drive away: a self-heating timeout that lapses after a fixed time, a filtered overcurrent trip, and a latched thermal shutdown that software must release by hand.

The pin can also be turned around into an input. In that mode the driver is held off, and every transition seen by the pin-level comparator raises the interrupt. A synchronized copy of the comparator output is always readable, whatever the mode. The short status and the interrupt stay set until software clears each of them with its own one-cycle clear pulse.

All time constants are counted in ticks of a free-running prescaler, so the counters stay narrow. With a 20.48 MHz clock the default settings give a 25 µs tick, a 1.3 s drive timeout and a 400 µs short filter.

Top module: `wake_ctl`

## Requirements
- R1: After reset, drv_en, short_sts, irq, therm_lock and pin_lvl are all 0.
- R2: With io_mode=0 and nothing blocking, drv_en follows a rise of drv_req on the next clock and stays high while drv_req is held.
- R3: With mono_dis=0, drv_en falls after MONO_TICKS ticks of drive (between MONO_TICKS-1 and MONO_TICKS+1 tick periods) even if drv_req stays high. A fresh rising edge of drv_req restarts the full interval.
- R4: With mono_dis=1, drv_en stays high for as long as drv_req is high, and falls once drv_req is cleared.
- R5: oc_raw held high during drive for at least SHORT_TICKS+1 tick periods sets short_sts and irq and turns drv_en off. The driver stays off until the next rising edge of drv_req. A pulse on oc_raw shorter than SHORT_TICKS-1 tick periods changes nothing.
- R6: A therm_evt pulse while therm_ovr=0 sets therm_lock and turns drv_en off. Both hold until a therm_reen pulse.
- R7: While therm_ovr=1, therm_evt has no effect on drv_en or therm_lock.
- R8: While io_mode=1, drv_en is 0 and each rising or falling edge of pin_cmp sets irq within four clocks.
- R9: pin_lvl equals pin_cmp delayed by two clocks, in either mode.
- R10: short_sts clears only on sts_clr and irq clears only on irq_clr; neither clear touches the other flag. Edges of pin_cmp while io_mode=0 do not set irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_req | input | 1 | Software wake drive request |
| mono_dis | input | 1 | 1 turns off the drive timeout |
| therm_ovr | input | 1 | 1 stops thermal events from shutting the driver off |
| therm_reen | input | 1 | One-cycle pulse that releases the thermal lock |
| io_mode | input | 1 | 1 makes the pin an input with edge interrupts |
| sts_clr | input | 1 | One-cycle pulse that clears short_sts |
| irq_clr | input | 1 | One-cycle pulse that clears irq |
| oc_raw | input | 1 | Unfiltered overcurrent comparator flag |
| therm_evt | input | 1 | Thermal event flag |
| pin_cmp | input | 1 | Pin-level comparator output, asynchronous |
| drv_en | output | 1 | Enable for the external high-side driver |
| short_sts | output | 1 | Sticky short-circuit status |
| therm_lock | output | 1 | Driver held off by a thermal event |
| pin_lvl | output | 1 | Synchronized pin level |
| irq | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that oc_raw, therm_evt and the configuration inputs are synchronous to clk. They also assume that each clear or re-enable input is a single-cycle pulse. Only pin_cmp is allowed to arrive asynchronously, which is why it passes through the synchronizer. The bench changes every input on the falling clock edge and samples outputs there too. Where the tick phase cannot be known, it keeps each timed stimulus at least one full tick clear of the thresholds, so every expected value stays fixed.

// File: rtl/wake_ctl.sv
module wake_ctl #(
  parameter int PRESCALE    = 512,
  parameter int MONO_TICKS  = 52000,
  parameter int SHORT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_req,
  input  logic mono_dis,
  input  logic therm_ovr,
  input  logic therm_reen,
  input  logic io_mode,
  input  logic sts_clr,
  input  logic irq_clr,
  input  logic oc_raw,
  input  logic therm_evt,
  input  logic pin_cmp,
  output logic drv_en,
  output logic short_sts,
  output logic therm_lock,
  output logic pin_lvl,
  output logic irq
);

  localparam int PW = $clog2(PRESCALE);
  localparam int MW = $clog2(MONO_TICKS + 1);
  localparam int SW = $clog2(SHORT_TICKS + 1);

  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] mono_cnt;
  logic [SW-1:0] oc_cnt;
  logic          tick, req_q, req_rise;
  logic          mono_done, short_lock, trip;
  logic          pin_s1, pin_s2, pin_s3, edge_hit;

  assign tick     = (pre_cnt == PW'(PRESCALE - 1));
  assign req_rise = drv_req & ~req_q;
  assign drv_en   = req_q & ~io_mode & ~therm_lock & ~short_lock & ~(mono_done & ~mono_dis);
  assign trip     = drv_en & oc_raw & tick & (oc_cnt == SW'(SHORT_TICKS - 1));
  assign edge_hit = io_mode & (pin_s2 ^ pin_s3);
  assign pin_lvl  = pin_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      req_q   <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      req_q   <= drv_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mono_cnt  <= '0;
      mono_done <= 1'b0;
    end else if (req_rise) begin
      mono_cnt  <= '0;
      mono_done <= 1'b0;
    end else if (drv_en && !mono_dis && tick) begin
      if (mono_cnt == MW'(MONO_TICKS - 1)) mono_done <= 1'b1;
      else mono_cnt <= mono_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_cnt     <= '0;
      short_lock <= 1'b0;
    end else begin
      if (!oc_raw || !drv_en || trip) oc_cnt <= '0;
      else if (tick) oc_cnt <= oc_cnt + 1'b1;
      if (trip) short_lock <= 1'b1;
      else if (req_rise) short_lock <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_lock <= 1'b0;
      short_sts  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (therm_evt && !therm_ovr) therm_lock <= 1'b1;
      else if (therm_reen) therm_lock <= 1'b0;
      if (trip) short_sts <= 1'b1;
      else if (sts_clr) short_sts <= 1'b0;
      if (trip || edge_hit) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
      pin_s3 <= 1'b0;
    end else begin
      pin_s1 <= pin_cmp;
      pin_s2 <= pin_s1;
      pin_s3 <= pin_s2;
    end
  end

  // R3
  mono_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mono_cnt < MW'(MONO_TICKS));

  // R5
  short_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_sts) |-> irq);

  // R5
  short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_sts) |-> !drv_en);

  // R6
  therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_evt && !therm_ovr) |=> !drv_en);

  // R8
  edge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_mode && (pin_s2 != pin_s3)) |=> irq);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

// File: tb/tb_wake_ctl.sv
module tb_wake_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4, MONO = 20, SHRT = 5;

  logic clk = 0, rst_n = 0;
  logic drv_req = 0, mono_dis = 0, therm_ovr = 0, therm_reen = 0, io_mode = 0;
  logic sts_clr = 0, irq_clr = 0, oc_raw = 0, therm_evt = 0, pin_cmp = 0;
  logic drv_en, short_sts, therm_lock, pin_lvl, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctl #(.PRESCALE(PRE), .MONO_TICKS(MONO), .SHORT_TICKS(SHRT)) dut (
    .clk(clk), .rst_n(rst_n), .drv_req(drv_req), .mono_dis(mono_dis),
    .therm_ovr(therm_ovr), .therm_reen(therm_reen), .io_mode(io_mode),
    .sts_clr(sts_clr), .irq_clr(irq_clr), .oc_raw(oc_raw), .therm_evt(therm_evt),
    .pin_cmp(pin_cmp), .drv_en(drv_en), .short_sts(short_sts),
    .therm_lock(therm_lock), .pin_lvl(pin_lvl), .irq(irq));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(2);
    check("R1", "drv_en", drv_en, 0);
    check("R1", "short_sts", short_sts, 0);
    check("R1", "irq", irq, 0);
    check("R1", "therm_lock", therm_lock, 0);
    check("R1", "pin_lvl", pin_lvl, 0);
  endtask

  task automatic t_drive_and_mono;
    drv_req = 1; cyc(2);
    check("R2", "drv_en after request", drv_en, 1);
    cyc(58);
    check("R3", "drv_en before timeout", drv_en, 1);
    cyc(40);
    check("R3", "drv_en after timeout", drv_en, 0);
    drv_req = 0; cyc(2);
    drv_req = 1; cyc(2);
    check("R3", "drv_en after restart", drv_en, 1);
    cyc(60);
    check("R3", "restart gives full interval", drv_en, 1);
    drv_req = 0; cyc(2);
  endtask

  task automatic t_mono_off;
    mono_dis = 1; drv_req = 1; cyc(200);
    check("R4", "drv_en held with timeout off", drv_en, 1);
    drv_req = 0; cyc(3);
    check("R4", "drv_en after release", drv_en, 0);
    mono_dis = 0; cyc(2);
  endtask

  task automatic t_short;
    drv_req = 1; cyc(3);
    oc_raw = 1; cyc(10); oc_raw = 0; cyc(5);
    check("R5", "glitch keeps drive", drv_en, 1);
    check("R5", "glitch no status", short_sts, 0);
    check("R5", "glitch no irq", irq, 0);
    oc_raw = 1; cyc(40); oc_raw = 0; cyc(2);
    check("R5", "short status", short_sts, 1);
    check("R5", "short irq", irq, 1);
    check("R5", "short drives off", drv_en, 0);
    cyc(10);
    check("R5", "stays off until new request", drv_en, 0);
    check("R10", "status sticky", short_sts, 1);
    @(negedge clk) sts_clr = 1; @(negedge clk) sts_clr = 0; cyc(1);
    check("R10", "sts_clr clears status", short_sts, 0);
    check("R10", "sts_clr leaves irq", irq, 1);
    @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; cyc(1);
    check("R10", "irq_clr clears irq", irq, 0);
    drv_req = 0; cyc(2); drv_req = 1; cyc(3);
    check("R5", "new request re-enables", drv_en, 1);
    drv_req = 0; cyc(2);
  endtask

  task automatic t_thermal;
    drv_req = 1; cyc(3);
    @(negedge clk) therm_evt = 1; @(negedge clk) therm_evt = 0; cyc(1);
    check("R6", "thermal drives off", drv_en, 0);
    check("R6", "thermal lock set", therm_lock, 1);
    cyc(8);
    check("R6", "lock holds", drv_en, 0);
    @(negedge clk) therm_reen = 1; @(negedge clk) therm_reen = 0; cyc(1);
    check("R6", "lock released", therm_lock, 0);
    check("R6", "drive back", drv_en, 1);
    drv_req = 0; cyc(2);
    therm_ovr = 1; drv_req = 1; cyc(3);
    @(negedge clk) therm_evt = 1; @(negedge clk) therm_evt = 0; cyc(2);
    check("R7", "override keeps drive", drv_en, 1);
    check("R7", "override no lock", therm_lock, 0);
    drv_req = 0; therm_ovr = 0; cyc(2);
  endtask

  task automatic t_io;
    pin_cmp = 1; cyc(1);
    check("R9", "pin_lvl not yet", pin_lvl, 0);
    cyc(1);
    check("R9", "pin_lvl after two clocks", pin_lvl, 1);
    cyc(3);
    check("R10", "no irq outside io mode", irq, 0);
    pin_cmp = 0; cyc(4);
    io_mode = 1; drv_req = 1; cyc(3);
    check("R8", "io mode holds driver off", drv_en, 0);
    pin_cmp = 1; cyc(4);
    check("R8", "rising edge irq", irq, 1);
    check("R9", "pin_lvl in io mode", pin_lvl, 1);
    @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; cyc(1);
    check("R10", "irq cleared", irq, 0);
    pin_cmp = 0; cyc(4);
    check("R8", "falling edge irq", irq, 1);
    @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0;
    io_mode = 0; drv_req = 0; cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_drive_and_mono();
    t_mono_off();
    t_short();
    t_thermal();
    t_io();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule